// File: doc/BRIEF.md
# Decimating Sample Formatter

This block sits in one stream's datapath ahead of the framing logic. It takes a stream of 32-bit samples, lowers their rate, formats them, and hands out 32-bit words. Rate reduction works in one of two ways. Drop mode keeps one sample out of every N. Averaging mode outputs the mean of each run of N consecutive samples, where N is a power of two.

Before decimation, each sample can be sign-extended from a bit position set by the user. Output words carry either one 32-bit sample, or two 16-bit samples packed together. The configuration pins are plain levels. Whenever their value changes, the decimation phase, the accumulator and the 16-bit pairing all restart.

Both data interfaces use valid/ready. An input sample is taken on a clock edge where `in_valid` and `in_ready` are both high. An output word moves on an edge where `out_valid` and `out_ready` are both high. The output is a single register. While that register holds a word that has not been taken, the word stays unchanged and `in_ready` is low. `in_ready` therefore equals `!out_valid || out_ready`, and no sample is ever dropped because of back-pressure.

Top module: `dsf_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold and `in_ready` is 0. Every accepted sample is counted toward decimation exactly once.
- R3: Drop mode (`cfg_avg_en`=0, 32-bit) forwards the first accepted sample of each group of N, where N is `cfg_div`. A divisor of 0 acts as 1. The word appears in the cycle after the kept sample is accepted.
- R4: Drop mode with `cfg_half_width`=1 lowers an odd divisor greater than 1 by one, so it uses 1 or an even N.
- R5: With `cfg_avg_en`=1, N is the largest power of two not above `cfg_div` (0 acts as 1), capped at 4096. The output is the sum of N consecutive formatted samples, shifted right by log2(N). The shift is arithmetic when `cfg_sign_en`=1 and logical when it is 0.
- R6: With `cfg_sign_en`=1, every bit of an incoming sample above `cfg_sign_pos` (0..31) is replaced by the bit at `cfg_sign_pos`. This happens before decimation.
- R7: With `cfg_sign_en`=0, samples enter decimation unchanged. In drop mode with N=1 in 32-bit mode, each word equals its input sample.
- R8: With `cfg_half_width`=1, the low 16 bits of two consecutive decimated samples form one word. The earlier sample goes in bits 15:0 and the later one in bits 31:16.
- R9: Any change of the configuration pins clears the phase count, the accumulator, and a pending unpaired 16-bit half. The next accepted sample starts a fresh group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | 16 | Decimation divisor |
| cfg_avg_en | input | 1 | 1 selects averaging, 0 selects dropping |
| cfg_sign_pos | input | 5 | Bit position of the sign |
| cfg_sign_en | input | 1 | 1 turns on sign extension and the arithmetic shift |
| cfg_half_width | input | 1 | 0 gives 32-bit words, 1 gives packed 16-bit pairs |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 32 | Input sample |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Sink takes the output word |
| out_data | output | 32 | Output word |

## Verification
The hardest case to reach is a configuration change that lands while state is half built. That means an accumulator partly filled, or one 16-bit half waiting for its partner, possibly while an output word is stalled by back-pressure. The stimulus feeds a few samples into a long averaging window or into the pairing stage, then changes the configuration while the input is idle. The bench model discards its own partial state at the same point, and the bench checks that the words that follow start from a clean group. Random gaps on the input and random drops of `out_ready` run through every mode, so stalls overlap group boundaries.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int DATA_W      = 32;
  localparam int DIV_W       = 16;
  localparam int POS_W       = 5;
  localparam int AVG_LOG_MAX = 12;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             avg_en;
    logic [POS_W-1:0] sign_pos;
    logic             sign_en;
    logic             half;
  } dsf_cfg_t;
endpackage

// File: rtl/dsf_sign_ext.sv
module dsf_sign_ext #(
  parameter int DW = 32,
  parameter int PW = 5
) (
  input  logic          en,
  input  logic [PW-1:0] pos,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic sign_bit;
  assign sign_bit = din[pos];

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign dout[b] = (en && (PW'(b) > pos)) ? sign_bit : din[b];
  end
endmodule

// File: rtl/dsf_decimator.sv
module dsf_decimator #(
  parameter int DW      = 32,
  parameter int CW      = 16,
  parameter int LOG_MAX = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic          avg_en,
  input  logic          half_mode,
  input  logic          sign_en,
  input  logic [CW-1:0] div,
  input  logic [DW-1:0] sample,
  output logic          fire,
  output logic [DW-1:0] value
);
  localparam int AW = DW + LOG_MAX;
  localparam int KW = $clog2(LOG_MAX + 1);

  function automatic logic [KW-1:0] floor_log2(input logic [CW-1:0] v);
    logic [KW-1:0] r;
    r = '0;
    for (int i = 0; i < CW; i++) begin
      if (v[i]) r = (i > LOG_MAX) ? KW'(LOG_MAX) : KW'(i);
    end
    return r;
  endfunction

  logic [CW-1:0] div_eff, n_drop, n_avg, limit, phase_q, phase_cur;
  logic [KW-1:0] k;
  logic [AW-1:0] acc_q, acc_cur, ext, sum;
  logic          last;
  logic [DW-1:0] avg_val;

  assign div_eff   = (div == '0) ? CW'(1) : div;
  assign n_drop    = (half_mode && div_eff != CW'(1)) ? {div_eff[CW-1:1], 1'b0} : div_eff;
  assign k         = floor_log2(div_eff);
  assign n_avg     = CW'(1) << k;
  assign limit     = avg_en ? n_avg : n_drop;

  assign phase_cur = restart ? '0 : phase_q;
  assign acc_cur   = restart ? '0 : acc_q;
  assign last      = (phase_cur == limit - CW'(1));

  assign ext = sign_en ? {{(AW-DW){sample[DW-1]}}, sample} : {{(AW-DW){1'b0}}, sample};
  assign sum = acc_cur + ext;

  assign avg_val = sign_en ? DW'($signed(sum) >>> k) : DW'(sum >> k);
  assign fire    = step && (avg_en ? last : (phase_cur == '0));
  assign value   = avg_en ? avg_val : sample;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      acc_q   <= '0;
    end else if (step) begin
      phase_q <= last ? '0 : phase_cur + CW'(1);
      acc_q   <= (avg_en && !last) ? sum : '0;
    end else if (restart) begin
      phase_q <= '0;
      acc_q   <= '0;
    end
  end
endmodule

// File: rtl/dsf_packer.sv
module dsf_packer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          fire,
  input  logic          half_mode,
  input  logic [DW-1:0] value,
  output logic          word_fire,
  output logic [DW-1:0] word
);
  localparam int HW = DW / 2;

  logic          half_q, half_cur;
  logic [HW-1:0] low_q;

  assign half_cur  = restart ? 1'b0 : half_q;
  assign word_fire = half_mode ? (fire && half_cur) : fire;
  assign word      = half_mode ? {value[HW-1:0], low_q} : value;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      low_q  <= '0;
    end else if (fire && half_mode) begin
      if (half_cur) begin
        half_q <= 1'b0;
      end else begin
        half_q <= 1'b1;
        low_q  <= value[HW-1:0];
      end
    end else if (restart || !half_mode) begin
      half_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dsf_top.sv
module dsf_top
  import dsf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_avg_en,
  input  logic [POS_W-1:0]  cfg_sign_pos,
  input  logic              cfg_sign_en,
  input  logic              cfg_half_width,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  dsf_cfg_t          cfg, cfg_q;
  logic              restart, step, dec_fire, word_fire;
  logic [DATA_W-1:0] formatted, dec_value, word;

  assign cfg = '{div: cfg_div, avg_en: cfg_avg_en, sign_pos: cfg_sign_pos,
                 sign_en: cfg_sign_en, half: cfg_half_width};

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= cfg;
    else        cfg_q <= cfg;
  end

  assign restart  = (cfg != cfg_q);
  assign in_ready = !out_valid || out_ready;
  assign step     = in_valid && in_ready;

  dsf_sign_ext #(.DW(DATA_W), .PW(POS_W)) u_sext (
    .en  (cfg.sign_en),
    .pos (cfg.sign_pos),
    .din (in_data),
    .dout(formatted)
  );

  dsf_decimator #(.DW(DATA_W), .CW(DIV_W), .LOG_MAX(AVG_LOG_MAX)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .step     (step),
    .avg_en   (cfg.avg_en),
    .half_mode(cfg.half),
    .sign_en  (cfg.sign_en),
    .div      (cfg.div),
    .sample   (formatted),
    .fire     (dec_fire),
    .value    (dec_value)
  );

  dsf_packer #(.DW(DATA_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .fire     (dec_fire),
    .half_mode(cfg.half),
    .value    (dec_value),
    .word_fire(word_fire),
    .word     (word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (step && word_fire) begin
      out_valid <= 1'b1;
      out_data  <= word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker
  import dsf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DIV_W-1:0]  cfg_div,
  input logic              cfg_avg_en,
  input logic [POS_W-1:0]  cfg_sign_pos,
  input logic              cfg_sign_en,
  input logic              cfg_half_width,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  logic direct_path;
  assign direct_path = in_valid && in_ready && (cfg_div == DIV_W'(1)) &&
                       !cfg_avg_en && !cfg_half_width;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_path && !cfg_sign_en) |=> (out_valid && out_data == $past(in_data)));

  assert_sign_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_path && cfg_sign_en) |=> (out_data[DATA_W-1] == $past(in_data[cfg_sign_pos])));
endmodule

bind dsf_top dsf_checker u_chk (.*);

// File: tb/dsf_top_test.sv
`timescale 1ns/1ps
module dsf_top_test;
  logic        clk = 0, rst_n = 0;
  logic [15:0] cfg_div = 16'd1;
  logic        cfg_avg_en = 0, cfg_sign_en = 0, cfg_half_width = 0;
  logic [4:0]  cfg_sign_pos = 5'd31;
  logic        in_valid = 0, out_ready = 1;
  logic [31:0] in_data = 0;
  logic        in_ready, out_valid;
  logic [31:0] out_data;

  int checks = 0, fails = 0;
  string tag = "R1";
  int ready_mode = 1; // 0 hold low, 1 always high, 2 random

  logic [31:0] expq[$];
  int m_ph; longint m_acc; bit m_hf; logic [15:0] m_low;

  dsf_top uut (.*);

  always #5 clk = ~clk;

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(logic [31:0] x);
    logic [31:0] r = x;
    if (cfg_sign_en) for (int i = 0; i < 32; i++) if (i > cfg_sign_pos) r[i] = x[cfg_sign_pos];
    return r;
  endfunction

  function automatic int eff_n();
    int d = (cfg_div == 0) ? 1 : int'(cfg_div);
    if (cfg_avg_en) begin
      int p = 1;
      while (p * 2 <= d && p < 4096) p = p * 2;
      return p;
    end
    if (cfg_half_width && d > 1 && d % 2 == 1) d = d - 1;
    return d;
  endfunction

  function automatic int log2i(int n);
    int k = 0;
    while ((1 << k) < n) k++;
    return k;
  endfunction

  task automatic emit(logic [31:0] v);
    if (!cfg_half_width) expq.push_back(v);
    else if (!m_hf) begin m_low = v[15:0]; m_hf = 1; end
    else begin expq.push_back({v[15:0], m_low}); m_hf = 0; end
  endtask

  task automatic model_push(logic [31:0] d);
    logic [31:0] x = sext(d);
    int n = eff_n();
    if (cfg_avg_en) begin
      m_acc += cfg_sign_en ? longint'($signed(x)) : longint'({32'd0, x});
      m_ph++;
      if (m_ph == n) begin
        emit(cfg_sign_en ? 32'(m_acc >>> log2i(n)) : 32'(m_acc >> log2i(n)));
        m_ph = 0; m_acc = 0;
      end
    end else begin
      if (m_ph == 0) emit(x);
      m_ph = (m_ph + 1 == n) ? 0 : m_ph + 1;
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (in_valid && in_ready) model_push(in_data);
    if (out_valid && out_ready) begin
      if (expq.size() == 0) check({tag, " unexpected word"}, out_data, 32'hx);
      else check(tag, out_data, expq.pop_front());
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = (ready_mode == 0) ? 1'b0 : (ready_mode == 1) ? 1'b1 : (($urandom % 3) != 0);
  end

  task automatic configure(int dv, bit av, int pos, bit se, bit hw);
    @(posedge clk); #2;
    in_valid = 0;
    cfg_div = 16'(dv); cfg_avg_en = av; cfg_sign_pos = 5'(pos);
    cfg_sign_en = se; cfg_half_width = hw;
    m_ph = 0; m_acc = 0; m_hf = 0;
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic send(logic [31:0] d);
    bit ok;
    while (($urandom % 4) == 0) begin in_valid = 0; @(posedge clk); #2; end
    in_valid = 1; in_data = d;
    do begin @(negedge clk); ok = in_ready; @(posedge clk); #2; end while (!ok);
    in_valid = 0;
  endtask

  task automatic drain();
    int w = 0;
    while ((expq.size() != 0 || out_valid) && w < 200) begin @(posedge clk); w++; end
    #2;
    check({tag, " drained"}, 32'(expq.size()), 32'd0);
  endtask

  task automatic run(string t, int n, int dv, bit av, int pos, bit se, bit hw);
    tag = t;
    configure(dv, av, pos, se, hw);
    for (int i = 0; i < n; i++) send($urandom);
    drain();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R2 directed stall: one word held while sink not ready
    ready_mode = 0;
    configure(1, 0, 31, 0, 0);
    tag = "R2";
    in_valid = 1; in_data = 32'hCAFE_1234;
    @(posedge clk); #2; in_valid = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 held valid", {31'd0, out_valid}, 32'd1);
      check("R2 held data", out_data, 32'hCAFE_1234);
      check("R2 in_ready low", {31'd0, in_ready}, 32'd0);
    end
    ready_mode = 1;
    drain();

    ready_mode = 2;
    run("R7 passthrough", 40, 1, 0, 31, 0, 0);
    run("R2 random stall", 60, 3, 0, 31, 0, 0);
    run("R3 drop by 5", 53, 5, 0, 31, 0, 0);
    run("R3 divisor zero", 20, 0, 0, 31, 0, 0);
    run("R4 odd divisor 16-bit", 62, 7, 0, 31, 0, 1);
    run("R8 pack 16-bit", 40, 1, 0, 7, 1, 1);
    run("R6 sign pos 11", 30, 1, 0, 11, 1, 0);
    run("R6 sign pos 0", 20, 2, 0, 0, 1, 0);
    run("R5 avg 4 signed", 64, 4, 1, 11, 1, 0);
    run("R5 avg 100 unsigned", 256, 100, 1, 31, 0, 0);
    run("R5 avg full-width signed", 96, 8, 1, 31, 1, 0);
    run("R5 avg cap 4096", 8192, 65535, 1, 31, 0, 0);
    run("R5 avg 16-bit pack", 64, 4, 1, 15, 1, 1);

    // R9: partial accumulator and lone half discarded on configuration change
    tag = "R9 avg restart";
    configure(8, 1, 31, 0, 0);
    for (int i = 0; i < 3; i++) send($urandom);
    configure(4, 1, 31, 0, 0);
    for (int i = 0; i < 16; i++) send($urandom);
    drain();
    tag = "R9 pair restart";
    configure(1, 0, 31, 0, 1);
    send(32'h0000_AAAA);
    configure(1, 0, 15, 1, 1);
    for (int i = 0; i < 10; i++) send($urandom);
    drain();
    tag = "R9 drop restart";
    configure(6, 0, 31, 0, 0);
    for (int i = 0; i < 4; i++) send($urandom);
    configure(5, 0, 31, 0, 0);
    for (int i = 0; i < 21; i++) send($urandom);
    drain();

    summary();
  end
endmodule